// File: doc/BRIEF.md
# Descriptor Ring Port Controller

This block is the control and status logic for one storage port that works through a ring of 32-byte command descriptors. Host software builds descriptors in memory and programs the ring base address. It then writes a producer index. While the queue is enabled and not paused, the block reads the first word of each pending descriptor through a simple memory read port. It hands that word to the transport layer, waits for the transport to report success or failure, and then retires the descriptor by advancing the consumer index. The consumer index wraps after a programmable last-slot value.

Software controls the queue through a control register. That register holds an enable bit and three request bits: pause, abort and queue reset. The block answers each request with an acknowledge bit in a status register. Bits in the status register are cleared by writing 1 to them. The status register also records completions, device-change events, link faults and detailed transport error causes. A level interrupt is raised whenever a status bit is set and its bit in the interrupt mask register is also set.

The register window sits at fixed byte offsets so that the port's address decoder can select it. The transport layer, scatter-gather walking and bus mastering are all outside this block.

Top module: `dring_port`

## Requirements
- R1: After reset, the interrupt output, the memory request and the transport request are low. Every register reads 0, except the last-slot register, which reads 3.
- R2: The registers sit at these byte offsets: ring base low 0xA0, ring base high 0xA4, producer index 0xA8, consumer index 0xAC, control 0xB0, last slot 0xB4, status 0xB8, interrupt mask 0xBC. Base, producer, control, last-slot and mask read back what was written. Writes to the consumer index have no effect.
- R3: While control bit 0 (enable) is 1, control bit 1 (pause) is 0 and the producer index differs from the consumer index, descriptors are fetched in slot order until the two indices are equal. Slot n is read at address base + 32·n.
- R4: The consumer index goes from the last-slot value to 0. A last-slot write below 3 is stored as 3, so the smallest ring has four slots.
- R5: The control-flags byte is bits 15:8 of the fetched word. A descriptor with flag bit 4 (skip) set is retired without a transport request. Otherwise the word is passed to the transport. On success the consumer index advances, and status bit 0 (done) is set only if flag bit 0 (interrupt on completion) is set.
- R6: On a transport error, status bit 5 is set and the error cause bits 0..6 are copied into status bits 16..22. The consumer index stays where it is. The engine stays halted until the queue is disabled or reset; after re-enabling, it retries the same slot.
- R7: A pause request lets the descriptor in flight finish and then sets status bit 1 once. No fetch starts while the pause bit is set. Clearing the bit resumes fetching.
- R8: An abort request (control bit 2) drops the descriptor in flight without advancing the consumer index, sets status bit 2 and halts the engine.
- R9: A queue reset request (control bit 3) clears both the producer and the consumer index, ends a halt and sets status bit 3.
- R10: Writing 1 to a status bit clears it; writing 0 leaves it unchanged. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R11: The interrupt output is 1 exactly when some status bit and the same interrupt mask bit are both 1.
- R12: A device-change input pulse sets status bit 4. A link-fault input pulse sets status bits 6 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset within the port |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Descriptor word read request, held until mem_rvalid |
| mem_addr | output | 64 | Byte address of the descriptor being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | First word of the descriptor |
| xfer_req | output | 1 | Descriptor handed to the transport, held until it answers |
| xfer_desc | output | 32 | Descriptor word for the transport |
| xfer_done | input | 1 | Transport finished the descriptor successfully |
| xfer_err | input | 1 | Transport failed the descriptor |
| xfer_err_code | input | 7 | Error cause bits, valid with xfer_err |
| dev_change | input | 1 | Device presence change pulse |
| link_fault | input | 1 | Serial link fault pulse |
| irq | output | 1 | Level interrupt |

## Verification
Two things can hit the status register in the same cycle. The engine can set the done bit as the transport completes a descriptor flagged for interrupt on completion, while the host writes 1 to that same bit. The bench provokes this by holding the transport's answer and then, on a single clock edge, driving the success pulse together with a status write that clears bit 0. It passes only if bit 0 reads back as 1 and the consumer index has advanced. Pause and abort requests that arrive while a descriptor is in the transport stage are timed the same way, to show that the pause waits for the completion and the abort drops it.

// File: rtl/dring_pkg.sv
package dring_pkg;

    // Register byte offsets inside the port window (decoded by the port mux)
    localparam logic [7:0] OFF_BASE_LO = 8'hA0;
    localparam logic [7:0] OFF_BASE_HI = 8'hA4;
    localparam logic [7:0] OFF_PROD    = 8'hA8;
    localparam logic [7:0] OFF_CONS    = 8'hAC;
    localparam logic [7:0] OFF_CTRL    = 8'hB0;
    localparam logic [7:0] OFF_LAST    = 8'hB4;
    localparam logic [7:0] OFF_STAT    = 8'hB8;
    localparam logic [7:0] OFF_MASK    = 8'hBC;

    // Control bits
    localparam int C_EN    = 0;
    localparam int C_PAUSE = 1;
    localparam int C_ABORT = 2;
    localparam int C_RESET = 3;
    localparam int CTRL_W  = 4;

    // Status bits
    localparam int S_DONE   = 0;
    localparam int S_PACK   = 1;
    localparam int S_AACK   = 2;
    localparam int S_RACK   = 3;
    localparam int S_DEVCHG = 4;
    localparam int S_CMDERR = 5;
    localparam int S_LINK   = 6;
    localparam int S_DET_LO = 16;
    localparam int DET_W    = 7;
    localparam logic [31:0] STAT_IMPL = 32'h007F_007F;

    // Descriptor layout
    localparam int DESC_SHIFT = 5;   // 32-byte descriptors
    localparam int FLAG_LSB   = 8;   // control-flags byte of word 0
    localparam int F_EIN      = 0;
    localparam int F_SKIP     = 4;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_EXEC   = 3'd2,
        ST_PAUSED = 3'd3,
        ST_HALT   = 3'd4
    } eng_state_e;

endpackage

// File: rtl/dring_regs.sv
module dring_regs
    import dring_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int MIN_LAST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [7:0]        addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic [IDX_W-1:0]  cons_i,
    input  logic              ev_done_i,
    input  logic              ev_pause_i,
    input  logic              ev_abort_i,
    input  logic              ev_reset_i,
    input  logic              ev_err_i,
    input  logic [DET_W-1:0]  err_code_i,
    input  logic              dev_change_i,
    input  logic              link_fault_i,
    input  logic              clr_prod_i,
    output logic [63:0]       base_o,
    output logic [IDX_W-1:0]  prod_o,
    output logic [IDX_W-1:0]  last_o,
    output logic              en_o,
    output logic              pause_o,
    output logic              abort_o,
    output logic              rst_req_o,
    output logic              irq_o
);

    localparam logic [IDX_W-1:0] LAST_FLOOR = IDX_W'(MIN_LAST);
    localparam int PAD_W = 32 - IDX_W;

    typedef struct packed {
        logic [31:0]       base_lo;
        logic [31:0]       base_hi;
        logic [IDX_W-1:0]  prod;
        logic [CTRL_W-1:0] ctrl;
        logic [IDX_W-1:0]  last;
        logic [31:0]       status;
        logic [31:0]       imask;
    } regs_t;

    regs_t q, d;
    logic [31:0] set_vec;
    logic [31:0] clr_vec;

    always_comb begin
        set_vec = '0;
        set_vec[S_DONE]   = ev_done_i;
        set_vec[S_PACK]   = ev_pause_i;
        set_vec[S_AACK]   = ev_abort_i;
        set_vec[S_RACK]   = ev_reset_i;
        set_vec[S_DEVCHG] = dev_change_i;
        set_vec[S_CMDERR] = ev_err_i | link_fault_i;
        set_vec[S_LINK]   = link_fault_i;
        if (ev_err_i) begin
            set_vec[S_DET_LO +: DET_W] = err_code_i;
        end
        clr_vec = (wr_i && addr_i == OFF_STAT) ? wdata_i : '0;

        d = q;
        if (wr_i) begin
            case (addr_i)
                OFF_BASE_LO: d.base_lo = wdata_i;
                OFF_BASE_HI: d.base_hi = wdata_i;
                OFF_PROD:    d.prod    = wdata_i[IDX_W-1:0];
                OFF_CTRL:    d.ctrl    = wdata_i[CTRL_W-1:0];
                OFF_LAST:    d.last    = (wdata_i[IDX_W-1:0] < LAST_FLOOR) ?
                                         LAST_FLOOR : wdata_i[IDX_W-1:0];
                OFF_MASK:    d.imask   = wdata_i;
                default:     ;
            endcase
        end
        if (clr_prod_i) begin
            d.prod = '0;
        end
        // an event in the same cycle as a clear keeps the bit set
        d.status = ((q.status & ~clr_vec) | set_vec) & STAT_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.base_lo <= '0;
            q.base_hi <= '0;
            q.prod    <= '0;
            q.ctrl    <= '0;
            q.last    <= LAST_FLOOR;
            q.status  <= '0;
            q.imask   <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (addr_i)
            OFF_BASE_LO: rdata_o = q.base_lo;
            OFF_BASE_HI: rdata_o = q.base_hi;
            OFF_PROD:    rdata_o = {{PAD_W{1'b0}}, q.prod};
            OFF_CONS:    rdata_o = {{PAD_W{1'b0}}, cons_i};
            OFF_CTRL:    rdata_o = {{(32-CTRL_W){1'b0}}, q.ctrl};
            OFF_LAST:    rdata_o = {{PAD_W{1'b0}}, q.last};
            OFF_STAT:    rdata_o = q.status;
            OFF_MASK:    rdata_o = q.imask;
            default:     rdata_o = '0;
        endcase
    end

    assign base_o    = {q.base_hi, q.base_lo};
    assign prod_o    = q.prod;
    assign last_o    = q.last;
    assign en_o      = q.ctrl[C_EN];
    assign pause_o   = q.ctrl[C_PAUSE];
    assign abort_o   = q.ctrl[C_ABORT];
    assign rst_req_o = q.ctrl[C_RESET];
    assign irq_o     = |(q.status & q.imask);

    // R10: every event bit raised in a cycle is visible in status afterwards
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=>
        ((q.status & $past(set_vec & STAT_IMPL)) == $past(set_vec & STAT_IMPL)));

    // R9: a queue reset empties the producer index
    a_r9_prod_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_prod_i |=> (q.prod == '0));

endmodule

// File: rtl/dring_engine.sv
module dring_engine
    import dring_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int AW    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              pause_i,
    input  logic              abort_i,
    input  logic              rst_req_i,
    input  logic [AW-1:0]     base_i,
    input  logic [IDX_W-1:0]  prod_i,
    input  logic [IDX_W-1:0]  last_i,
    input  logic              mem_rvalid_i,
    input  logic [31:0]       mem_rdata_i,
    input  logic              xfer_done_i,
    input  logic              xfer_err_i,
    output logic [IDX_W-1:0]  cons_o,
    output logic              mem_req_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic              xfer_req_o,
    output logic [31:0]       xfer_desc_o,
    output logic              ev_done_o,
    output logic              ev_pause_o,
    output logic              ev_abort_o,
    output logic              ev_reset_o,
    output logic              ev_err_o,
    output logic              clr_prod_o
);

    localparam int OFS_PAD = AW - IDX_W - DESC_SHIFT;

    typedef struct packed {
        eng_state_e       st;
        logic [IDX_W-1:0] cons;
        logic [31:0]      word;
        logic             abt_acked;
        logic             rst_acked;
    } eng_t;

    eng_t q, d;
    logic [IDX_W-1:0] cons_inc;

    assign cons_inc = (q.cons == last_i) ? '0 : q.cons + IDX_W'(1);

    always_comb begin
        d          = q;
        ev_done_o  = 1'b0;
        ev_pause_o = 1'b0;
        ev_abort_o = 1'b0;
        ev_reset_o = 1'b0;
        ev_err_o   = 1'b0;
        clr_prod_o = 1'b0;
        if (!abort_i)   d.abt_acked = 1'b0;
        if (!rst_req_i) d.rst_acked = 1'b0;

        if (rst_req_i && !q.rst_acked) begin
            d.st        = ST_IDLE;
            d.cons      = '0;
            d.rst_acked = 1'b1;
            ev_reset_o  = 1'b1;
            clr_prod_o  = 1'b1;
        end else if (abort_i && !q.abt_acked) begin
            d.st        = ST_HALT;
            d.abt_acked = 1'b1;
            ev_abort_o  = 1'b1;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    if (en_i) begin
                        if (pause_i) begin
                            d.st       = ST_PAUSED;
                            ev_pause_o = 1'b1;
                        end else if (prod_i != q.cons) begin
                            d.st = ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_rvalid_i) begin
                        d.word = mem_rdata_i;
                        if (mem_rdata_i[FLAG_LSB + F_SKIP]) begin
                            d.cons = cons_inc;
                            d.st   = ST_IDLE;
                        end else begin
                            d.st = ST_EXEC;
                        end
                    end
                end
                ST_EXEC: begin
                    if (xfer_err_i) begin
                        d.st     = ST_HALT;
                        ev_err_o = 1'b1;
                    end else if (xfer_done_i) begin
                        d.cons    = cons_inc;
                        d.st      = ST_IDLE;
                        ev_done_o = q.word[FLAG_LSB + F_EIN];
                    end
                end
                ST_PAUSED: begin
                    if (!pause_i) d.st = ST_IDLE;
                end
                ST_HALT: begin
                    if (!en_i) d.st = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.cons      <= '0;
            q.word      <= '0;
            q.abt_acked <= 1'b0;
            q.rst_acked <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cons_o      = q.cons;
    assign mem_req_o   = (q.st == ST_FETCH);
    assign xfer_req_o  = (q.st == ST_EXEC);
    assign xfer_desc_o = q.word;
    assign mem_addr_o  = base_i + {{OFS_PAD{1'b0}}, q.cons, {DESC_SHIFT{1'b0}}};

    // R3: a fetch only starts when work is pending and the queue may run
    a_r3_fetch_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> $past(en_i && !pause_i && (prod_i != q.cons)));

    // R4: the consumer index only steps by one or wraps to zero
    a_r4_cons_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.cons) |-> ((q.cons == '0) || (q.cons == $past(q.cons) + IDX_W'(1))));

    // R5: a skipped descriptor never reaches the transport
    a_r5_skip_not_sent: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> !q.word[FLAG_LSB + F_SKIP]);

    // R6: while halted, the consumer index holds until a queue reset
    a_r6_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HALT && !rst_req_i) |=> $stable(q.cons));

    // R8: a fresh abort drops any fetch or transfer in the next cycle
    a_r8_abort_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !rst_req_i && !q.abt_acked) |=> (!mem_req_o && !xfer_req_o));

endmodule

// File: rtl/dring_port.sv
module dring_port
    import dring_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int MIN_LAST = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic [63:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        xfer_req,
    output logic [31:0] xfer_desc,
    input  logic        xfer_done,
    input  logic        xfer_err,
    input  logic [6:0]  xfer_err_code,
    input  logic        dev_change,
    input  logic        link_fault,
    output logic        irq
);

    logic [63:0]      base;
    logic [IDX_W-1:0] prod, cons, last;
    logic             en, pause, abort, rst_req;
    logic             ev_done, ev_pause, ev_abort, ev_reset, ev_err, clr_prod;

    dring_regs #(.IDX_W(IDX_W), .MIN_LAST(MIN_LAST)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (reg_wr),
        .addr_i       (reg_addr),
        .wdata_i      (reg_wdata),
        .rdata_o      (reg_rdata),
        .cons_i       (cons),
        .ev_done_i    (ev_done),
        .ev_pause_i   (ev_pause),
        .ev_abort_i   (ev_abort),
        .ev_reset_i   (ev_reset),
        .ev_err_i     (ev_err),
        .err_code_i   (xfer_err_code),
        .dev_change_i (dev_change),
        .link_fault_i (link_fault),
        .clr_prod_i   (clr_prod),
        .base_o       (base),
        .prod_o       (prod),
        .last_o       (last),
        .en_o         (en),
        .pause_o      (pause),
        .abort_o      (abort),
        .rst_req_o    (rst_req),
        .irq_o        (irq)
    );

    dring_engine #(.IDX_W(IDX_W), .AW(64)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .pause_i      (pause),
        .abort_i      (abort),
        .rst_req_i    (rst_req),
        .base_i       (base),
        .prod_i       (prod),
        .last_i       (last),
        .mem_rvalid_i (mem_rvalid),
        .mem_rdata_i  (mem_rdata),
        .xfer_done_i  (xfer_done),
        .xfer_err_i   (xfer_err),
        .cons_o       (cons),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .xfer_req_o   (xfer_req),
        .xfer_desc_o  (xfer_desc),
        .ev_done_o    (ev_done),
        .ev_pause_o   (ev_pause),
        .ev_abort_o   (ev_abort),
        .ev_reset_o   (ev_reset),
        .ev_err_o     (ev_err),
        .clr_prod_o   (clr_prod)
    );

endmodule

// File: tb/tb_dring_port.sv
`timescale 1ns/1ps
module tb_dring_port;

    localparam logic [63:0] BASE = 64'h0000_0012_3456_7800;
    localparam logic [7:0] A_BLO = 8'hA0, A_BHI = 8'hA4, A_PROD = 8'hA8, A_CONS = 8'hAC;
    localparam logic [7:0] A_CTRL = 8'hB0, A_LAST = 8'hB4, A_STAT = 8'hB8, A_MASK = 8'hBC;
    // vector: [9] transport expected, [8] done expected, [7:0] flags byte
    localparam logic [9:0] VEC [6] = '{10'h301, 10'h200, 10'h341, 10'h010, 10'h011, 10'h383};

    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        mem_req, mem_rvalid = 0;
    logic [63:0] mem_addr;
    logic [31:0] mem_rdata = 0;
    logic        xfer_req, xfer_done = 0, xfer_err = 0;
    logic [31:0] xfer_desc;
    logic [6:0]  xfer_err_code = 7'b0000101;
    logic        dev_change = 0, link_fault = 0, irq;

    int          n_chk = 0, n_fail = 0, xfer_cnt = 0, tp_mode = 0;
    logic [7:0]  desc_flags [4];
    logic [7:0]  last_flags = 0;
    logic [63:0] last_addr = 0, off;
    logic [31:0] v;
    bit          finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    dring_port dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .xfer_req(xfer_req), .xfer_desc(xfer_desc), .xfer_done(xfer_done),
        .xfer_err(xfer_err), .xfer_err_code(xfer_err_code),
        .dev_change(dev_change), .link_fault(link_fault), .irq(irq)
    );

    // descriptor memory: answers one cycle after a request
    initial forever begin
        @(negedge clk);
        if (mem_req && !mem_rvalid) begin
            mem_rvalid = 1;
            last_addr  = mem_addr;
            off        = (mem_addr - BASE) >> 5;
            mem_rdata  = {16'h0, desc_flags[off[1:0]], 8'h5A};
        end else begin
            mem_rvalid = 0;
        end
    end

    // transport: mode 0 succeeds, 1 fails, 2 holds (test drives it)
    initial forever begin
        @(negedge clk);
        if (tp_mode != 2) begin
            if (xfer_req && !xfer_done && !xfer_err) begin
                last_flags = xfer_desc[15:8];
                xfer_cnt++;
                if (tp_mode == 1) xfer_err = 1; else xfer_done = 1;
            end else begin
                xfer_done = 0;
                xfer_err  = 0;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic int nxt(input int i);
        return (i == 3) ? 0 : i + 1;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cs, cnt0, ps;
        for (int i = 0; i < 4; i++) desc_flags[i] = 8'h00;
        cyc(3);
        rst_n = 1;
        cyc(1);

        // R1: reset state
        check("R1 irq", irq, 0);
        check("R1 mem_req", mem_req, 0);
        check("R1 xfer_req", xfer_req, 0);
        rd(A_STAT, v); check("R1 status", v, 0);
        rd(A_LAST, v); check("R1 last slot", v, 3);
        rd(A_PROD, v); check("R1 prod", v, 0);
        rd(A_CTRL, v); check("R1 ctrl", v, 0);

        // R2: register map and read-only consumer index
        wr(A_BLO, BASE[31:0]); wr(A_BHI, BASE[63:32]); wr(A_MASK, 32'h1);
        rd(A_BLO, v); check("R2 base low", v, BASE[31:0]);
        rd(A_BHI, v); check("R2 base high", v, BASE[63:32]);
        rd(A_MASK, v); check("R2 mask", v, 32'h1);
        wr(A_CONS, 32'h5); rd(A_CONS, v); check("R2 cons read-only", v, 0);

        // R4: last-slot floor
        wr(A_LAST, 32'h1); rd(A_LAST, v); check("R4 floor", v, 3);
        wr(A_LAST, 32'h3);
        wr(A_CTRL, 32'h1);

        // vector table: R3 R4 R5 R11
        cs = 0;
        for (int i = 0; i < 6; i++) begin
            desc_flags[cs] = VEC[i][7:0];
            wr(A_STAT, 32'hFFFF_FFFF);
            cnt0 = xfer_cnt;
            ps = nxt(cs);
            wr(A_PROD, ps);
            cyc(8);
            rd(A_CONS, v); check("R4 cons advance/wrap", v, ps);
            rd(A_STAT, v); check("R5 done bit", v[0], VEC[i][8]);
            check("R11 irq follows masked done", irq, VEC[i][8]);
            check("R5 transport issued", xfer_cnt - cnt0, VEC[i][9]);
            if (VEC[i][9]) check("R5 flags to transport", last_flags, VEC[i][7:0]);
            check("R3 fetch address", last_addr, BASE + 64'(cs) * 32);
            cs = ps;
        end

        // R3: several descriptors pending at once
        for (int i = 0; i < 4; i++) desc_flags[i] = 8'h00;
        cnt0 = xfer_cnt;
        ps = nxt(nxt(nxt(cs)));
        wr(A_PROD, ps);
        cyc(16);
        rd(A_CONS, v); check("R3 batch cons", v, ps);
        check("R3 batch count", xfer_cnt - cnt0, 3);
        cs = ps;

        // R6: error halts without retiring
        wr(A_STAT, 32'hFFFF_FFFF);
        desc_flags[cs] = 8'h01;
        tp_mode = 1;
        wr(A_PROD, nxt(cs));
        cyc(8);
        rd(A_STAT, v); check("R6 error status", v, 32'h0005_0020);
        rd(A_CONS, v); check("R6 cons held", v, cs);
        tp_mode = 0;
        cyc(8);
        rd(A_CONS, v); check("R6 still halted", v, cs);
        wr(A_CTRL, 32'h0); wr(A_CTRL, 32'h1);
        cyc(8);
        rd(A_CONS, v); check("R6 retry after disable", v, nxt(cs));
        cs = nxt(cs);

        // R10: write-one-to-clear leaves other bits
        wr(A_STAT, 32'h20);
        rd(A_STAT, v); check("R10 w1c selective", v, 32'h0005_0001);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); check("R10 clear all", v, 0);

        // R7: pause waits for the descriptor in flight
        tp_mode = 2;
        desc_flags[cs] = 8'h00;
        wr(A_PROD, nxt(cs));
        cyc(5);
        check("R7 in flight", xfer_req, 1);
        wr(A_CTRL, 32'h3);
        cyc(4);
        rd(A_STAT, v); check("R7 no ack while busy", v[1], 0);
        @(negedge clk); xfer_done = 1;
        @(negedge clk); xfer_done = 0;
        cyc(3);
        rd(A_STAT, v); check("R7 pause ack", v, 32'h2);
        rd(A_CONS, v); check("R7 in-flight retired", v, nxt(cs));
        cs = nxt(cs);
        tp_mode = 0;
        desc_flags[cs] = 8'h00;
        wr(A_PROD, nxt(cs));
        cyc(8);
        rd(A_CONS, v); check("R7 no fetch while paused", v, cs);
        check("R7 mem idle", mem_req, 0);
        wr(A_CTRL, 32'h1);
        cyc(8);
        rd(A_CONS, v); check("R7 resume", v, nxt(cs));
        cs = nxt(cs);

        // R8: abort drops the descriptor in flight
        wr(A_STAT, 32'hFFFF_FFFF);
        tp_mode = 2;
        wr(A_PROD, nxt(cs));
        cyc(5);
        check("R8 in flight", xfer_req, 1);
        wr(A_CTRL, 32'h5);
        cyc(4);
        rd(A_STAT, v); check("R8 abort ack", v, 32'h4);
        check("R8 transfer dropped", xfer_req, 0);
        rd(A_CONS, v); check("R8 cons held", v, cs);
        tp_mode = 0;
        cyc(8);
        rd(A_CONS, v); check("R8 halted", v, cs);

        // R9: queue reset clears both indices
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h9);
        cyc(4);
        rd(A_STAT, v); check("R9 reset ack", v, 32'h8);
        rd(A_PROD, v); check("R9 prod cleared", v, 0);
        rd(A_CONS, v); check("R9 cons cleared", v, 0);
        wr(A_CTRL, 32'h1);
        desc_flags[0] = 8'h01;
        wr(A_PROD, 32'h1);
        cyc(8);
        rd(A_CONS, v); check("R9 runs after reset", v, 1);
        cs = 1;

        // R10: completion and clear in the same cycle
        wr(A_STAT, 32'hFFFF_FFFF);
        tp_mode = 2;
        desc_flags[cs] = 8'h01;
        wr(A_PROD, nxt(cs));
        cyc(5);
        check("R10 in flight", xfer_req, 1);
        @(negedge clk);
        reg_wr = 1; reg_addr = A_STAT; reg_wdata = 32'h1; xfer_done = 1;
        @(negedge clk);
        reg_wr = 0; xfer_done = 0;
        cyc(2);
        rd(A_STAT, v); check("R10 set wins", v[0], 1);
        rd(A_CONS, v); check("R10 cons advanced", v, nxt(cs));
        tp_mode = 0;

        // R12 and R11: side events and masking
        wr(A_STAT, 32'hFFFF_FFFF);
        @(negedge clk); dev_change = 1;
        @(negedge clk); dev_change = 0;
        rd(A_STAT, v); check("R12 device change", v, 32'h10);
        check("R11 masked off", irq, 0);
        wr(A_MASK, 32'h10);
        cyc(1);
        check("R11 masked on", irq, 1);
        wr(A_STAT, 32'hFFFF_FFFF);
        @(negedge clk); link_fault = 1;
        @(negedge clk); link_fault = 0;
        rd(A_STAT, v); check("R12 link fault", v, 32'h60);
        check("R11 other bit unmasked", irq, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule